// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block is the master side of a stereo serial audio link. From a single system clock it makes a bit clock and a frame clock by integer division. It then sends one left and one right sample per frame, MSB first, on a single data line. A frame always holds 64 bit-clock periods, split into two halves of 32. The sample word is placed inside each half by one of four formats: I2S, left-justified, 24-bit right-justified and 16-bit right-justified.

Stereo pairs enter through a valid/ready handshake into a one-deep staging register. At each frame boundary the staged pair moves into the active pair, and the staging slot frees up for the next one. The format select is a plain input that is sampled once per frame, at the frame boundary.

Top module: `audtx_top`

## Requirements
- R1: `bck_o` has a period of `CLK_DIV` system clocks, high for `CLK_DIV/2` and low for `CLK_DIV/2`.
- R2: Every frame has 64 bit-clock periods. `lrck_o` and `dout_o` change only on the system clock edge at which `bck_o` falls.
- R3: With format code 0 (I2S), `lrck_o` is low for the left half. The 24-bit word occupies bit periods 1 to 24 of its half, MSB first. All other bit periods carry 0.
- R4: With format code 1 (left-justified), `lrck_o` is high for the left half. The 24-bit word occupies bit periods 0 to 23, MSB first. All other bit periods carry 0.
- R5: With format code 2 (24-bit right-justified), `lrck_o` is high for the left half. The word occupies bit periods 8 to 31, so its LSB is in the last period of the half. Periods 0 to 7 carry 0.
- R6: With format code 3 (16-bit right-justified), `lrck_o` is high for the left half. Bits [15:0] of the sample occupy periods 16 to 31, MSB first, and bits [23:16] of the sample are not sent. Periods 0 to 15 carry 0.
- R7: The format code is taken from `fmt_i` at the frame boundary. A change of `fmt_i` during a frame does not alter that frame's LRCK polarity or data placement.
- R8: `pair_ready_o` is high while the staging slot is empty. A pair is taken on a clock edge where `pair_valid_i` and `pair_ready_o` are both high. `pair_ready_o` is then low until the next frame boundary moves the pair into the active pair.
- R9: If no pair is staged at a frame boundary, both halves of that frame carry all-zero data, with the LRCK pattern of the latched format.
- R10: While reset is asserted, `bck_o`, `lrck_o` and `dout_o` are low and `pair_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_DIV x 64 x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Format code: 0 I2S, 1 left-justified, 2 right-justified 24, 3 right-justified 16 |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| pair_valid_i | input | 1 | Offered pair is valid |
| pair_ready_o | output | 1 | Staging slot is empty |
| bck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame (channel) clock |
| dout_o | output | 1 | Serial data |

## Verification
`bck_o` rises `CLK_DIV/2` system clocks after it falls. `lrck_o` and `dout_o` for a bit period become valid on the edge where `bck_o` falls, so the monitor samples them 1 ns after each `bck_o` rise, half a bit period after they settle. A pair accepted on edge N drops `pair_ready_o` right after edge N. That pair appears on the line in the frame that starts at the next frame boundary, so the driver pushes the 64 expected (LRCK, data) entries of that frame when the pair is accepted, and the monitor pops one entry per bit-clock rise. Duty cycle and edge alignment are checked at every system clock falling edge, against the bit clock's level one clock earlier.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S      = 2'd0,
    FMT_LJ       = 2'd1,
    FMT_RJ_LONG  = 2'd2,
    FMT_RJ_SHORT = 2'd3
  } fmt_e;

  localparam int unsigned HALF_BITS  = 32;
  localparam int unsigned FRAME_BITS = 2 * HALF_BITS;
  localparam int unsigned SLOT_W     = $clog2(FRAME_BITS);
endpackage

// File: rtl/audtx_clkdiv.sv
module audtx_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bck_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF  = DIV / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bck_q;

  // fall_o marks the edge at which bck drops and line data advances
  assign fall_o = (cnt_q == CNT_W'(DIV - 1));
  assign cnt_d  = fall_o ? '0 : cnt_q + 1'b1;
  assign bck_o  = bck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bck_q <= (cnt_d >= CNT_W'(HALF));
    end
  end

  // R1
  bck_toggle_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bck_q) |-> (cnt_q == '0 || cnt_q == CNT_W'(HALF)));

  // R1
  bck_low_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !bck_q);
endmodule

// File: rtl/audtx_framer.sv
module audtx_framer
  import audtx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  fmt_e fmt_i,
  output logic frame_start_o,
  output logic half_start_o,
  output logic right_half_o,
  output fmt_e fmt_o,
  output logic lrck_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  fmt_e              fmt_q;
  logic              lrck_q;

  assign slot_d        = slot_q + 1'b1;
  assign frame_start_o = fall_i && (slot_q == '1);
  assign half_start_o  = fall_i && (slot_q[SLOT_W-2:0] == '1);
  assign right_half_o  = slot_d[SLOT_W-1];
  // format is fixed for the frame from its first bit on
  assign fmt_o         = frame_start_o ? fmt_i : fmt_q;
  assign lrck_o        = lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '1;
      fmt_q  <= FMT_I2S;
      lrck_q <= 1'b0;
    end else if (fall_i) begin
      slot_q <= slot_d;
      lrck_q <= (fmt_o == FMT_I2S) ? slot_d[SLOT_W-1] : ~slot_d[SLOT_W-1];
      if (frame_start_o) fmt_q <= fmt_i;
    end
  end

  // R2
  lrck_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_q) |-> $past(fall_i));

  // R7
  fmt_frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(fmt_q));

  // R2
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> (slot_q == '0));
endmodule

// File: rtl/audtx_shifter.sv
module audtx_shifter
  import audtx_pkg::*;
#(
  parameter int unsigned W       = 24,
  parameter int unsigned SHORT_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         frame_start_i,
  input  logic         half_start_i,
  input  logic         right_half_i,
  input  fmt_e         fmt_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic         valid_i,
  output logic         ready_o,
  output logic         dout_o
);
  localparam int unsigned HB = HALF_BITS;

  logic [W-1:0]  stg_l_q, stg_r_q, act_l_q, act_r_q;
  logic          stg_v_q;
  logic          accept;
  logic [W-1:0]  word, wsel;
  logic [HB-1:0] base, aligned, sh_q;
  logic [5:0]    off;
  logic          dout_q;

  assign ready_o = ~stg_v_q;
  assign accept  = valid_i & ~stg_v_q;
  assign dout_o  = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_l_q <= '0;
      stg_r_q <= '0;
      act_l_q <= '0;
      act_r_q <= '0;
      stg_v_q <= 1'b0;
    end else begin
      if (frame_start_i) begin
        act_l_q <= stg_v_q ? stg_l_q : '0;
        act_r_q <= stg_v_q ? stg_r_q : '0;
        stg_v_q <= 1'b0;
      end
      if (accept) begin
        stg_l_q <= left_i;
        stg_r_q <= right_i;
        stg_v_q <= 1'b1;
      end
    end
  end

  // left word is taken straight from staging since the active pair updates on the same edge
  always_comb begin
    word = right_half_i ? act_r_q : (stg_v_q ? stg_l_q : '0);
    wsel = (fmt_i == FMT_RJ_SHORT) ? (W'(word[SHORT_W-1:0]) << (W - SHORT_W)) : word;
    base = HB'(wsel) << (HB - W);
    case (fmt_i)
      FMT_I2S:     off = 6'd1;
      FMT_LJ:      off = 6'd0;
      FMT_RJ_LONG: off = 6'(HB - W);
      default:     off = 6'(HB - SHORT_W);
    endcase
    aligned = base >> off;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else if (fall_i) begin
      if (half_start_i) begin
        dout_q <= aligned[HB-1];
        sh_q   <= aligned << 1;
      end else begin
        dout_q <= sh_q[HB-1];
        sh_q   <= sh_q << 1;
      end
    end
  end

  // R2
  dout_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_q) |-> $past(fall_i));

  // R8
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !frame_start_i) |=> !ready_o);

  // R8
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !frame_start_i) |=> !ready_o);

  // R9
  underrun_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !stg_v_q) |=> (act_l_q == '0 && act_r_q == '0));
endmodule

// File: rtl/audtx_top.sv
module audtx_top
  import audtx_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SHORT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                pair_valid_i,
  output logic                pair_ready_o,
  output logic                bck_o,
  output logic                lrck_o,
  output logic                dout_o
);
  logic fall;
  logic frame_start, half_start, right_half;
  fmt_e fmt_cur;

  audtx_clkdiv #(.DIV(CLK_DIV)) u_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bck_o  (bck_o),
    .fall_o (fall)
  );

  audtx_framer u_framer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_i        (fall),
    .fmt_i         (fmt_e'(fmt_i)),
    .frame_start_o (frame_start),
    .half_start_o  (half_start),
    .right_half_o  (right_half),
    .fmt_o         (fmt_cur),
    .lrck_o        (lrck_o)
  );

  audtx_shifter #(.W(SAMPLE_W), .SHORT_W(SHORT_W)) u_shifter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_i        (fall),
    .frame_start_i (frame_start),
    .half_start_i  (half_start),
    .right_half_i  (right_half),
    .fmt_i         (fmt_cur),
    .left_i        (left_i),
    .right_i       (right_i),
    .valid_i       (pair_valid_i),
    .ready_o       (pair_ready_o),
    .dout_o        (dout_o)
  );
endmodule

// File: tb/tb_audtx_top.sv
`timescale 1ns/1ps
module tb_audtx_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [23:0] left = '0, right = '0;
  logic        valid = 1'b0;
  logic        ready, bck, lrck, dout;

  int checks = 0;
  int fails = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] cur_fmt = 2'd0;

  always #2.5 clk = ~clk;

  audtx_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .left_i(left), .right_i(right),
    .pair_valid_i(valid), .pair_ready_o(ready), .bck_o(bck), .lrck_o(lrck), .dout_o(dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic exp_bit(input logic [1:0] f, input logic [23:0] w, input int p);
    case (f)
      2'd0:    return (p >= 1 && p <= 24) ? w[24-p] : 1'b0;
      2'd1:    return (p <= 23) ? w[23-p] : 1'b0;
      2'd2:    return (p >= 8) ? w[31-p] : 1'b0;
      default: return (p >= 16) ? w[31-p] : 1'b0;
    endcase
  endfunction

  task automatic push_frame(input logic [1:0] f, input logic [23:0] l, input logic [23:0] r,
                            input string tag);
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 32; p++) begin
        logic lr;
        lr = (f == 2'd0) ? logic'(h) : !logic'(h);
        exp_q.push_back({lr, exp_bit(f, (h != 0) ? r : l, p)});
        tag_q.push_back(tag);
      end
    end
  endtask

  // driver: pair k is offered right after frame k-1 starts, so it lands in frame k
  task automatic send_pair(input logic [1:0] f, input logic [23:0] l, input logic [23:0] r,
                           input string tag);
    do @(negedge clk); while (!ready);
    fmt = f; cur_fmt = f; left = l; right = r; valid = 1'b1;
    push_frame(f, l, r, tag);
    @(posedge clk);
    #1 valid = 1'b0;
    chk(ready == 1'b0, "R8 ready after accept", ready, 0);
  endtask

  // R9: let one frame boundary pass with an empty staging slot
  task automatic skip_frame();
    do @(negedge clk); while (!ready);
    push_frame(cur_fmt, 24'h0, 24'h0, "R9");
    repeat (260) @(posedge clk);
    #1;
    chk(ready == 1'b1, "R8 ready while empty", ready, 1);
  endtask

  // monitor: one scoreboard entry per bit-clock rise, skipping the pre-frame rise
  initial begin
    bit first = 1'b1;
    @(posedge rst_ni);
    forever begin
      @(posedge bck);
      #1;
      if (first) first = 1'b0;
      else if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        // R7: lrck polarity follows the format latched at the frame boundary
        chk(lrck === e[1], {t, " R7 lrck"}, lrck, e[1]);
        chk(dout === e[0], {t, " dout"}, dout, e[0]);
      end
    end
  end

  // R1 duty and R2 edge alignment, watched at every system clock falling edge
  initial begin
    logic pb, pd, pl;
    int run = 0;
    bit first_run = 1'b1;
    @(posedge rst_ni);
    @(negedge clk);
    pb = bck; pd = dout; pl = lrck; run = 1;
    forever begin
      @(negedge clk);
      if (bck != pb) begin
        if (first_run) first_run = 1'b0;
        else chk(run == DIV/2, "R1 bck run length", run, DIV/2);
        run = 1;
      end else run++;
      if (dout != pd || lrck != pl)
        chk(pb == 1'b1 && bck == 1'b0, "R2 change off bck fall", {pb, bck}, 2);
      pb = bck; pd = dout; pl = lrck;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10
    chk(bck == 1'b0, "R10 bck", bck, 0);
    chk(lrck == 1'b0, "R10 lrck", lrck, 0);
    chk(dout == 1'b0, "R10 dout", dout, 0);
    chk(ready == 1'b1, "R10 ready", ready, 1);
    @(negedge clk) rst_ni = 1'b1;

    send_pair(2'd0, 24'hA5C3F1, 24'h123456, "R3");
    send_pair(2'd1, 24'h800001, 24'h7FFFFE, "R4");
    send_pair(2'd2, 24'hF0F00F, 24'h0FF0F0, "R5");
    send_pair(2'd3, 24'hABCDEF, 24'h5A8001, "R6");
    send_pair(2'd0, 24'hFFFFFF, 24'h000001, "R3");
    skip_frame();
    send_pair(2'd1, 24'h3C3C3C, 24'hC3C3C3, "R4");
    send_pair(2'd3, 24'hFF8000, 24'h007FFF, "R6");
    send_pair(2'd2, 24'h000001, 24'h800000, "R5");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (8) @(posedge clk);
    finish_run();
  end
endmodule